// File: doc/BRIEF.md
# Fuse-Programmable Sum-of-Products Array

This block is a configurable two-level logic array. A set of input signals feeds a bank of product terms, and each product term is an AND over the input literals it is wired to. A bank of outputs then ORs together the product terms they are wired to. Every wiring point is a fuse bit. A fuse bit of 1 is intact, which means the connection is made. A fuse bit of 0 is blown, which means the connection is broken. The results for the degenerate cases are defined. A product term with no connections reads 1. An output with no connections reads 0.

A build-time mode can lock one of the two planes. In fixed-decoder mode, the AND plane is a full minterm decoder and only the OR plane is programmable, so the block acts like a small programmable ROM. In fixed-grouping mode, each output ORs its own factory-set slice of product terms and only the AND plane is programmable. In full mode, both planes are programmable, and any product term may drive any number of outputs.

The fuse pattern is loaded bit by bit through a serial shift port. It becomes active only when a load strobe is given. After that, the path from the inputs to the outputs is purely combinational.

Top module: `pla_array`

## Requirements
- R1: On reset, every fuse, both shifted and active, is intact (1). With the default sizes (3 inputs, 8 terms, 2 outputs), the outputs then read 0 in full mode, all ones in fixed-decoder mode, and 0 in fixed-grouping mode.
- R2: The chain length depends on the mode: 2·N·P + P·M bits in full mode, P·M in fixed-decoder mode, and 2·N·P in fixed-grouping mode. Bits enter MSB-first, so the first bit shifted lands in the highest position. The OR fuse for output o and term t sits at bit o·P+t. The AND fuses sit directly above the OR fuses (at base P·M in full mode, at base 0 in fixed-grouping mode). For term t and input i, the fuse on the true literal is at base+(t·N+i)·2+1 and the fuse on the complement literal is at base+(t·N+i)·2.
- R3: A rising edge of cfgClk shifts one bit from cfgData only while cfgEn is 1. With cfgEn at 0, cfgData is ignored.
- R4: The active fuses change only on a cfgClk edge with cfgLoad at 1. That edge copies the shift chain as it stood before the edge. Shifting alone never changes outVec.
- R5: A programmable product term is 1 exactly when no intact true-literal fuse sees its input at 0 and no intact complement-literal fuse sees its input at 1. A term with every fuse blown therefore reads 1.
- R6: A programmable product term whose fuses are all intact reads 0 for every input value.
- R7: A programmable output is the OR of the terms whose OR fuse is intact. An output whose OR fuses are all blown reads 0.
- R8: In fixed-decoder mode, P equals 2^N and term t is 1 exactly when inVec equals t.
- R9: In fixed-grouping mode, output o is the OR of terms o·(P/M) through (o+1)·(P/M)−1.
- R10: In full mode, a single product term with intact OR fuses on several outputs drives all of them.
- R11: outVec follows a change of inVec without any cfgClk edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfgClk | input | 1 | Configuration clock |
| cfgRstN | input | 1 | Asynchronous active-low reset; sets all fuses intact |
| cfgEn | input | 1 | Shift enable for the serial chain |
| cfgData | input | 1 | Serial fuse bit, MSB first |
| cfgLoad | input | 1 | Copies the shift chain into the active fuses |
| inVec | input | N | Logic inputs |
| outVec | output | M | Logic outputs |

## Verification
Each fuse is the only thing that decides one literal or one term-to-output link. A corrupted active fuse therefore shows up on outVec as soon as an input value reaches the affected term. This is why every loaded pattern is swept over all input values. A bad shift order or a misplaced chain slice moves whole rows of fuses, so it shows up on the first sweep after the load that follows. Early or spurious activation shows up as a change in outVec before cfgLoad, and the checks look for that between a shift and its load.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    ARR_FULL      = 2'd0,
    ARR_FIXED_AND = 2'd1,
    ARR_FIXED_OR  = 2'd2
  } arrMode_e;

  typedef struct packed {
    logic shiftEn;
    logic loadEn;
  } cfgStrobe_t;

  function automatic int fuseChainLen(arrMode_e mode, int n, int p, int m);
    case (mode)
      ARR_FIXED_AND: return p * m;
      ARR_FIXED_OR:  return 2 * n * p;
      default:       return 2 * n * p + p * m;
    endcase
  endfunction

endpackage

// File: rtl/pla_ctrl.sv
module pla_ctrl
  import pla_pkg::*;
(
  input  logic       cfgEn,
  input  logic       cfgLoad,
  output cfgStrobe_t strobe
);

  always_comb begin
    strobe.shiftEn = cfgEn;
    strobe.loadEn  = cfgLoad;
  end

endmodule

// File: rtl/pla_fuse_store.sv
module pla_fuse_store
  import pla_pkg::*;
#(
  parameter int CHAIN_LEN = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cfgStrobe_t           strobe,
  input  logic                 serIn,
  output logic [CHAIN_LEN-1:0] activeFuses
);

  logic [CHAIN_LEN-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '1;
      activeFuses <= '1;
    end else begin
      if (strobe.shiftEn) shiftReg <= {shiftReg[CHAIN_LEN-2:0], serIn};
      if (strobe.loadEn)  activeFuses <= shiftReg;
    end
  end

  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(shiftReg)) else $error("shift chain moved while idle"); // R3
  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> shiftReg[0] == $past(serIn)) else $error("serial bit lost"); // R2
  AST_FUSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadEn |=> $stable(activeFuses)) else $error("active fuses changed without load"); // R4
  AST_LOAD_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEn |=> activeFuses == $past(shiftReg)) else $error("load took wrong chain"); // R4

endmodule

// File: rtl/pla_and_or.sv
module pla_and_or
  import pla_pkg::*;
#(
  parameter int       NUM_IN    = 3,
  parameter int       NUM_TERMS = 8,
  parameter int       NUM_OUT   = 2,
  parameter arrMode_e MODE      = ARR_FULL,
  parameter int       CHAIN_LEN = 64
) (
  input  logic [NUM_IN-1:0]    inVec,
  input  logic [CHAIN_LEN-1:0] fuses,
  output logic [NUM_OUT-1:0]   outVec
);

  localparam int AND_BASE      = (MODE == ARR_FULL) ? NUM_TERMS * NUM_OUT : 0;
  localparam int TERMS_PER_OUT = NUM_TERMS / NUM_OUT;

  logic [NUM_TERMS-1:0] terms;

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    if (MODE == ARR_FIXED_AND) begin : g_dec
      assign terms[t] = (inVec == NUM_IN'(t));
    end else begin : g_prog
      logic [NUM_IN-1:0] trueF;
      logic [NUM_IN-1:0] compF;
      for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
        assign trueF[i] = fuses[AND_BASE + (t * NUM_IN + i) * 2 + 1];
        assign compF[i] = fuses[AND_BASE + (t * NUM_IN + i) * 2];
      end
      assign terms[t] = ~|((trueF & ~inVec) | (compF & inVec));
    end
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    if (MODE == ARR_FIXED_OR) begin : g_grp
      assign outVec[o] = |terms[o * TERMS_PER_OUT +: TERMS_PER_OUT];
    end else begin : g_sum
      assign outVec[o] = |(terms & fuses[o * NUM_TERMS +: NUM_TERMS]);
    end
  end

  if (MODE == ARR_FIXED_AND) begin : g_chk_dec
    always_comb begin
      if (!$isunknown(inVec)) begin
        AST_ONE_MINTERM: assert ($countones(terms) == 1) else $error("decoder not one-hot"); // R8
      end
    end
  end

  always_comb begin
    if (!$isunknown(terms) && !$isunknown(outVec) && (terms == '0)) begin
      AST_OUT_NEEDS_TERM: assert (outVec == '0) else $error("output high with no live term"); // R7
    end
  end

endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int       NUM_IN    = 3,
  parameter int       NUM_TERMS = 8,
  parameter int       NUM_OUT   = 2,
  parameter arrMode_e MODE      = ARR_FULL
) (
  input  logic               cfgClk,
  input  logic               cfgRstN,
  input  logic               cfgEn,
  input  logic               cfgData,
  input  logic               cfgLoad,
  input  logic [NUM_IN-1:0]  inVec,
  output logic [NUM_OUT-1:0] outVec
);

  localparam int CHAIN_LEN = fuseChainLen(MODE, NUM_IN, NUM_TERMS, NUM_OUT);

  cfgStrobe_t           strobe;
  logic [CHAIN_LEN-1:0] activeFuses;

  pla_ctrl ctrl_i (
    .cfgEn  (cfgEn),
    .cfgLoad(cfgLoad),
    .strobe (strobe)
  );

  pla_fuse_store #(.CHAIN_LEN(CHAIN_LEN)) store_i (
    .clk        (cfgClk),
    .rstN       (cfgRstN),
    .strobe     (strobe),
    .serIn      (cfgData),
    .activeFuses(activeFuses)
  );

  pla_and_or #(
    .NUM_IN   (NUM_IN),
    .NUM_TERMS(NUM_TERMS),
    .NUM_OUT  (NUM_OUT),
    .MODE     (MODE),
    .CHAIN_LEN(CHAIN_LEN)
  ) planes_i (
    .inVec (inVec),
    .fuses (activeFuses),
    .outVec(outVec)
  );

endmodule

// File: tb/pla_array_tb_top.sv
module pla_array_tb_top;
  import pla_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int LEN0 = 64;
  localparam int LEN1 = 16;
  localparam int LEN2 = 48;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] en;
  logic [2:0] dat;
  logic       load;
  logic [2:0] x;
  logic [1:0] o0, o1, o2;
  int         nChecks = 0;
  int         nBad = 0;
  logic [63:0] pending [3];
  logic [63:0] cur [3];
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  pla_array #(.MODE(ARR_FULL)) dut_i (
    .cfgClk(clk), .cfgRstN(rstN), .cfgEn(en[0]), .cfgData(dat[0]),
    .cfgLoad(load), .inVec(x), .outVec(o0));
  pla_array #(.MODE(ARR_FIXED_AND)) dutDec_i (
    .cfgClk(clk), .cfgRstN(rstN), .cfgEn(en[1]), .cfgData(dat[1]),
    .cfgLoad(load), .inVec(x), .outVec(o1));
  pla_array #(.MODE(ARR_FIXED_OR)) dutGrp_i (
    .cfgClk(clk), .cfgRstN(rstN), .cfgEn(en[2]), .cfgData(dat[2]),
    .cfgLoad(load), .inVec(x), .outVec(o2));

  function automatic logic [63:0] nextRand(logic [63:0] s);
    logic [63:0] v;
    v = s;
    v = v ^ (v << 13);
    v = v ^ (v >> 7);
    v = v ^ (v << 17);
    return v;
  endfunction

  // Expected outputs from R2, R5..R9: d=0 full, d=1 fixed decoder, d=2 fixed grouping
  function automatic logic [1:0] model(int d, logic [63:0] cfg, logic [2:0] xv);
    logic [7:0] tv;
    logic [1:0] r;
    int ab;
    ab = (d == 0) ? 16 : 0;
    for (int t = 0; t < 8; t++) begin
      if (d == 1) tv[t] = (xv == t[2:0]);
      else begin
        tv[t] = 1'b1;
        for (int i = 0; i < 3; i++) begin
          if (cfg[ab + (t*3+i)*2 + 1] && !xv[i]) tv[t] = 1'b0;
          if (cfg[ab + (t*3+i)*2] && xv[i]) tv[t] = 1'b0;
        end
      end
    end
    r = 2'b00;
    for (int o = 0; o < 2; o++) begin
      for (int t = 0; t < 8; t++) begin
        if (d == 2) begin
          if ((t / 4) == o && tv[t]) r[o] = 1'b1;
        end else if (cfg[o*8 + t] && tv[t]) r[o] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic shiftIn(input int d, input logic [63:0] v, input int len);
    for (int b = len - 1; b >= 0; b--) begin
      @(negedge clk);
      en[d]  = 1'b1;
      dat[d] = v[b];
    end
    @(negedge clk);
    en[d] = 1'b0;
    pending[d] = v;
  endtask

  task automatic pulseLoad();
    @(negedge clk);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    for (int d = 0; d < 3; d++) cur[d] = pending[d];
  endtask

  task automatic sweep(input string t0, input string t1, input string t2);
    for (int v = 0; v < 8; v++) begin
      x = v[2:0];
      #1;
      check(o0, model(0, cur[0], x), t0);
      check(o1, model(1, cur[1], x), t1);
      check(o2, model(2, cur[2], x), t2);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nBad++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    logic [63:0] a, b, c, hand;
    rstN = 1'b0; en = '0; dat = '0; load = 1'b0; x = '0;
    for (int d = 0; d < 3; d++) begin pending[d] = '1; cur[d] = '1; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset leaves every fuse intact
    sweep("R1 full", "R1 decoder", "R1 grouping");

    // R2 R10: hand pattern, only term 2 live as true a0, feeding both outputs
    hand = '1;
    for (int k = 0; k < 6; k++) hand[16 + 12 + k] = 1'b0;
    hand[16 + 13] = 1'b1;
    hand[15:0] = 16'h0404;
    shiftIn(0, hand, LEN0);
    pulseLoad();
    for (int v = 0; v < 8; v++) begin
      x = v[2:0];
      #1;
      check(o0, {x[0], x[0]}, "R2 R10 shared term");
    end

    // all fuses blown
    shiftIn(0, 64'h0, LEN0);
    shiftIn(1, 64'h0, LEN1);
    shiftIn(2, 64'h0, LEN2);
    pulseLoad();
    sweep("R7 full blown", "R7 decoder blown", "R5 R9 grouping blown");

    // R4: shifting without load must not reach the outputs
    seed = nextRand(seed); a = seed;
    shiftIn(0, a, LEN0);
    shiftIn(1, a & 64'hFFFF, LEN1);
    shiftIn(2, a & 64'hFFFF_FFFF_FFFF, LEN2);
    sweep("R4 full", "R4 decoder", "R4 grouping");
    pulseLoad();
    sweep("R6 R11 full", "R8 decoder", "R9 grouping");

    // R3: data wiggles with enable low, then a load
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      dat = 3'(k * 5 + 1);
    end
    pulseLoad();
    sweep("R3 full", "R3 decoder", "R3 grouping");

    // sparse AND planes: many all-blown terms
    for (int r = 0; r < 6; r++) begin
      seed = nextRand(seed); a = seed;
      seed = nextRand(seed); b = seed;
      seed = nextRand(seed); c = seed;
      shiftIn(0, ((a & b & c) & 64'hFFFF_FFFF_FFFF_0000) | (b & 64'hFFFF), LEN0);
      shiftIn(1, c & 64'hFFFF, LEN1);
      shiftIn(2, (r[0] ? (a & b) : (a & b & c)) & 64'hFFFF_FFFF_FFFF, LEN2);
      pulseLoad();
      sweep("R5 R7 full", "R8 decoder", "R5 R9 grouping");
    end

    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule